// File: doc/BRIEF.md
# Memory-mapped CRC calculator

This block computes a running cyclic redundancy check over words written to it through a plain register port: valid, write, address and data. Software sets the polynomial, the data width and the bit-order and inversion options in a control word. It loads a start value from the seed register, then streams data writes into the engine. Each accepted write advances the running state by 8, 16 or 32 bits in the same clock cycle.

The checksum register gives a read view of the running state. Bit reversal and inversion can be applied to that view without touching the state. This lets the same engine produce both the common non-reflected check values and the reflected ones.

Top module: `crc_regblock`

## Requirements
- R1: Word registers sit at byte offsets 0x0 (control), 0x4 (data), 0x8 (seed) and 0xC (checksum). A read (valid=1, write=0) returns data on `rd_data` in the next cycle. After reset, control reads 0, seed reads 0xFFFFFFFF, checksum reads 0 and the data offset reads 0.
- R2: Control bit 0 is the engine enable. Bits 31:30 select the polynomial, bits 29:28 the data width, bit 24 input reversal, bit 25 output reversal, bit 26 input inversion and bit 27 output inversion. These bits read back as written. Bit 1 and all other bits read 0.
- R3: A control write with bit 1 set copies the seed into the running state, whether or not the engine is enabled. The other control fields take the values of that same write.
- R4: A data write leaves the state unchanged while the enable bit is 0. A write to the checksum offset never changes anything.
- R5: Polynomial select 00 is 16-bit 0x1021, 01 is 8-bit 0x07, 10 is 16-bit 0x8005 and 11 is 32-bit 0x04C11DB7. Shifting is MSB first and non-reflected. Only the low bits that fit the selected width take part in the state and the view.
- R6: Width select 00 uses data bits 7:0, 01 uses bits 15:0 and 1x uses all 32 bits. Bytes enter the CRC least significant first, and all of them update the state in one cycle.
- R7: With input reversal on, the bits of each data byte are reversed before use. For example, 0xAABBCCDD is processed as 0x55DD33BB.
- R8: With input inversion on, the data is inverted bit by bit before use.
- R9: With output reversal on, the checksum view reverses the bits over the selected width. For example, 32-bit state 0xDD7B0F2E reads back as 0x74F0DEBB.
- R10: With output inversion on, the view is inverted within the selected width. Output options change only the view, never the running state.
- R11: Feeding the ASCII bytes "123456789" gives these values:
  - 0x29B1 for select 00 with seed 0xFFFF.
  - 0xF4 for select 01 with seed 0.
  - 0xFEE8 for select 10 with seed 0.
  - 0xFC891918 for select 11 with seed 0xFFFFFFFF and output inversion.
  - 0xCBF43926 when input reversal and output reversal are added to that last case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | REG_W | Write data |
| rd_data | output | REG_W | Registered read data, valid the cycle after a read |

## Verification
The assertions assume that reset is held for at least one clock before any access. They also assume that each cycle carries at most one access, so a seed reload and a data update never compete. The bench drives every access through single-access tasks on the falling edge, with idle cycles between them, and it holds reset for several cycles at the start. Offsets are always word aligned, matching the decode that the assertions presume.

// File: rtl/crc_regblock_pkg.sv
package crc_regblock_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    MODE_CCITT = 2'b00,
    MODE_C8    = 2'b01,
    MODE_C16   = 2'b10,
    MODE_C32   = 2'b11
  } crc_mode_e;

  localparam int OFS_CTL  = 'h0;
  localparam int OFS_DAT  = 'h4;
  localparam int OFS_SEED = 'h8;
  localparam int OFS_CHK  = 'hC;

  localparam logic [REG_W-1:0] SEED_RESET = '1;

  function automatic int mode_width(crc_mode_e m);
    case (m)
      MODE_C8:  return 8;
      MODE_C32: return 32;
      default:  return 16;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] mode_mask(crc_mode_e m);
    case (m)
      MODE_C8:  return 32'h0000_00FF;
      MODE_C32: return 32'hFFFF_FFFF;
      default:  return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] mode_poly(crc_mode_e m);
    case (m)
      MODE_CCITT: return 32'h0000_1021;
      MODE_C8:    return 32'h0000_0007;
      MODE_C16:   return 32'h0000_8005;
      default:    return 32'h04C1_1DB7;
    endcase
  endfunction

  // One byte, MSB first, through the selected polynomial.
  function automatic logic [REG_W-1:0] crc_step_byte(logic [REG_W-1:0] st,
                                                     logic [7:0] b,
                                                     crc_mode_e m);
    logic [REG_W-1:0] s;
    logic [REG_W-1:0] msk;
    int w;
    logic fb;
    msk = mode_mask(m);
    w   = mode_width(m);
    s   = st & msk;
    for (int i = 7; i >= 0; i--) begin
      fb = s[w-1] ^ b[i];
      s  = (s << 1) & msk;
      if (fb) s = s ^ mode_poly(m);
    end
    return s;
  endfunction

endpackage

// File: rtl/crc_in_prep.sv
module crc_in_prep
  import crc_regblock_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] data_i,
  input  logic         rev_en,
  input  logic         inv_en,
  output logic [W-1:0] data_o
);
  localparam int NB = W / 8;

  logic [W-1:0] rev_w;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign rev_w[8*k + j] = data_i[8*k + 7 - j];
    end
  end

  always_comb begin
    data_o = rev_en ? rev_w : data_i;
    if (inv_en) data_o = ~data_o;
  end
endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_regblock_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] data_i,
  input  crc_mode_e    mode_i,
  input  logic [1:0]   len_i,
  output logic [W-1:0] state_o
);
  localparam int NB = W / 8;

  logic [W-1:0] chain [NB+1];

  assign chain[0] = state_i;

  for (genvar k = 0; k < NB; k++) begin : g_stage
    assign chain[k+1] = crc_step_byte(chain[k], data_i[8*k +: 8], mode_i);
  end

  always_comb begin
    case (len_i)
      2'b00:   state_o = chain[1];
      2'b01:   state_o = chain[2];
      default: state_o = chain[NB];
    endcase
  end
endmodule

// File: rtl/crc_out_view.sv
module crc_out_view
  import crc_regblock_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] state_i,
  input  crc_mode_e    mode_i,
  input  logic         rev_en,
  input  logic         inv_en,
  output logic [W-1:0] view_o
);
  logic [W-1:0] msk;
  logic [W-1:0] base;
  logic [W-1:0] full_rev;
  int           sh;

  assign msk  = mode_mask(mode_i);
  assign base = state_i & msk;

  for (genvar j = 0; j < W; j++) begin : g_rev
    assign full_rev[j] = base[W-1-j];
  end

  always_comb begin
    sh     = W - mode_width(mode_i);
    view_o = rev_en ? (full_rev >> sh) : base;
    if (inv_en) view_o = ~view_o & msk;
  end
endmodule

// File: rtl/crc_regblock.sv
module crc_regblock
  import crc_regblock_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(OFS_DAT);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFS_SEED);
  localparam logic [ADDR_W-1:0] A_CHK  = ADDR_W'(OFS_CHK);

  logic             en_q, in_rev_q, out_rev_q, in_inv_q, out_inv_q;
  logic [1:0]       len_q;
  crc_mode_e        mode_q;
  logic [REG_W-1:0] seed_q, state_q, rdata_q;

  logic             wr, rd;
  logic [REG_W-1:0] prep_data, next_state, view, ctl_view;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  crc_in_prep #(.W(REG_W)) u_prep (
    .data_i (bus_wdata),
    .rev_en (in_rev_q),
    .inv_en (in_inv_q),
    .data_o (prep_data)
  );

  crc_core #(.W(REG_W)) u_core (
    .state_i (state_q),
    .data_i  (prep_data),
    .mode_i  (mode_q),
    .len_i   (len_q),
    .state_o (next_state)
  );

  crc_out_view #(.W(REG_W)) u_view (
    .state_i (state_q),
    .mode_i  (mode_q),
    .rev_en  (out_rev_q),
    .inv_en  (out_inv_q),
    .view_o  (view)
  );

  always_comb begin
    ctl_view        = '0;
    ctl_view[0]     = en_q;
    ctl_view[24]    = in_rev_q;
    ctl_view[25]    = out_rev_q;
    ctl_view[26]    = in_inv_q;
    ctl_view[27]    = out_inv_q;
    ctl_view[29:28] = len_q;
    ctl_view[31:30] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      in_rev_q  <= 1'b0;
      out_rev_q <= 1'b0;
      in_inv_q  <= 1'b0;
      out_inv_q <= 1'b0;
      len_q     <= 2'b00;
      mode_q    <= MODE_CCITT;
      seed_q    <= SEED_RESET;
      state_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (wr) begin
        case (bus_addr)
          A_CTL: begin
            en_q      <= bus_wdata[0];
            in_rev_q  <= bus_wdata[24];
            out_rev_q <= bus_wdata[25];
            in_inv_q  <= bus_wdata[26];
            out_inv_q <= bus_wdata[27];
            len_q     <= bus_wdata[29:28];
            mode_q    <= crc_mode_e'(bus_wdata[31:30]);
            if (bus_wdata[1]) state_q <= seed_q;
          end
          A_DAT:  if (en_q) state_q <= next_state;
          A_SEED: seed_q <= bus_wdata;
          default: ;
        endcase
      end
      if (rd) begin
        case (bus_addr)
          A_CTL:   rdata_q <= ctl_view;
          A_SEED:  rdata_q <= seed_q;
          A_CHK:   rdata_q <= view;
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rd_data = rdata_q;

  // R3: seed reload strobe
  p_init_seed_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_CTL && bus_wdata[1]) |=> (state_q == $past(seed_q)));

  // R4: disabled engine holds state
  p_disabled_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_DAT && !en_q) |=> $stable(state_q));

  // R4: checksum offset is read-only
  p_chk_readonly_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_CHK) |=> ($stable(state_q) && $stable(seed_q)));

  // R1: seed read returns stored seed next cycle
  p_seed_readback_r1: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == A_SEED) |=> (rd_data == $past(seed_q)));

  // R10: reading the view never alters state
  p_view_nochange_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == A_CHK) |=> $stable(state_q));
endmodule

// File: tb/sim_crc_regblock.sv
`timescale 1ns/1ps
module sim_crc_regblock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crc_regblock u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data)
  );

  // ---------------- reference model ----------------
  function automatic int rw(logic [1:0] m);
    return (m == 2'b01) ? 8 : (m == 2'b11) ? 32 : 16;
  endfunction
  function automatic logic [31:0] rmask(logic [1:0] m);
    return (rw(m) == 32) ? 32'hFFFF_FFFF : ((32'h1 << rw(m)) - 1);
  endfunction
  function automatic logic [31:0] rpoly(logic [1:0] m);
    case (m)
      2'b00: return 32'h1021;
      2'b01: return 32'h07;
      2'b10: return 32'h8005;
      default: return 32'h04C11DB7;
    endcase
  endfunction
  function automatic logic [31:0] ref_byte(logic [31:0] st, logic [7:0] b, logic [1:0] m);
    logic [31:0] s = st & rmask(m);
    for (int i = 7; i >= 0; i--) begin
      logic top = s[rw(m)-1];
      s = (s << 1) & rmask(m);
      if (top ^ b[i]) s ^= rpoly(m);
    end
    return s;
  endfunction
  function automatic logic [31:0] ref_word(logic [31:0] st, logic [31:0] d, logic [31:0] ctl);
    logic [31:0] x = d;
    int n;
    if (ctl[24]) for (int k = 0; k < 4; k++) for (int j = 0; j < 8; j++) x[8*k+j] = d[8*k+7-j];
    if (ctl[26]) x = ~x;
    n = (ctl[29:28] == 2'b00) ? 1 : (ctl[29:28] == 2'b01) ? 2 : 4;
    for (int k = 0; k < n; k++) st = ref_byte(st, x[8*k +: 8], ctl[31:30]);
    return st;
  endfunction
  function automatic logic [31:0] ref_view(logic [31:0] st, logic [31:0] ctl);
    logic [1:0] m = ctl[31:30];
    logic [31:0] v = st & rmask(m);
    logic [31:0] r = '0;
    if (ctl[25]) begin
      for (int j = 0; j < rw(m); j++) r[j] = v[rw(m)-1-j];
      v = r;
    end
    if (ctl[27]) v = ~v & rmask(m);
    return v;
  endfunction
  function automatic logic [31:0] mk_ctl(logic [1:0] mode, logic [1:0] len, logic oinv,
                                         logic iinv, logic orev, logic irev, logic en);
    return {mode, len, oinv, iinv, orev, irev, 22'b0, 1'b0, en};
  endfunction

  // ---------------- bus tasks ----------------
  task automatic bwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask
  task automatic brd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = rd_data;
  endtask
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask
  task automatic load(input logic [31:0] ctl, input logic [31:0] seed);
    bwr(4'h8, seed);
    bwr(4'h0, ctl | 32'h2);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    brd(4'h0, v); check("R1 ctl reset", v, 32'h0);
    brd(4'h8, v); check("R1 seed reset", v, 32'hFFFF_FFFF);
    brd(4'hC, v); check("R1 checksum reset", v, 32'h0);
    brd(4'h4, v); check("R1 data offset reads 0", v, 32'h0);
  endtask

  task automatic t_ctl_readback();
    logic [31:0] v;
    bwr(4'h0, 32'hFFFF_FFFF);
    brd(4'h0, v); check("R2 ctl all-ones readback", v, 32'hFF00_0001);
    bwr(4'h0, 32'h5A00_0000);
    brd(4'h0, v); check("R2 ctl pattern readback", v, 32'h5A00_0000);
  endtask

  task automatic t_check_values();
    logic [31:0] v, c, st;
    logic [31:0] cfg [5];
    logic [31:0] sd  [5];
    logic [31:0] exp [5];
    cfg[0] = mk_ctl(2'b00, 2'b00, 0, 0, 0, 0, 1); sd[0] = 32'hFFFF;     exp[0] = 32'h29B1;
    cfg[1] = mk_ctl(2'b01, 2'b00, 0, 0, 0, 0, 1); sd[1] = 32'h0;        exp[1] = 32'hF4;
    cfg[2] = mk_ctl(2'b10, 2'b00, 0, 0, 0, 0, 1); sd[2] = 32'h0;        exp[2] = 32'hFEE8;
    cfg[3] = mk_ctl(2'b11, 2'b00, 1, 0, 0, 0, 1); sd[3] = 32'hFFFFFFFF; exp[3] = 32'hFC891918;
    cfg[4] = mk_ctl(2'b11, 2'b00, 1, 0, 1, 1, 1); sd[4] = 32'hFFFFFFFF; exp[4] = 32'hCBF43926;
    for (int t = 0; t < 5; t++) begin
      load(cfg[t], sd[t]);
      st = sd[t];
      for (int k = 0; k < 9; k++) begin
        c = 32'hA5C3_7E00 | (32'h31 + k);   // upper bits must be ignored (R6)
        bwr(4'h4, c);
        st = ref_word(st, c, cfg[t]);
      end
      brd(4'hC, v);
      check("R11 standard check value", v, exp[t]);
      check("R5 model agrees with check value", ref_view(st, cfg[t]), exp[t]);
    end
  endtask

  task automatic t_lengths();
    logic [31:0] v, st, ctl;
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 4; l++) begin
        ctl = mk_ctl(m[1:0], l[1:0], 0, 0, 0, 0, 1);
        load(ctl, 32'h1357_9BDF);
        st = 32'h1357_9BDF;
        bwr(4'h4, 32'hDEAD_BEEF); st = ref_word(st, 32'hDEAD_BEEF, ctl);
        bwr(4'h4, 32'h0123_4567); st = ref_word(st, 32'h0123_4567, ctl);
        brd(4'hC, v);
        check("R6/R5 width and mode", v, ref_view(st, ctl));
      end
    end
  endtask

  task automatic t_in_rev();
    logic [31:0] a, b;
    load(mk_ctl(2'b11, 2'b10, 0, 0, 0, 1, 1), 32'h0BAD_F00D);
    bwr(4'h4, 32'hAABB_CCDD);
    brd(4'hC, a);
    load(mk_ctl(2'b11, 2'b10, 0, 0, 0, 0, 1), 32'h0BAD_F00D);
    bwr(4'h4, 32'h55DD_33BB);
    brd(4'hC, b);
    check("R7 per-byte input reversal", a, b);
  endtask

  task automatic t_in_inv();
    logic [31:0] a, b;
    load(mk_ctl(2'b10, 2'b01, 0, 1, 0, 0, 1), 32'h1234);
    bwr(4'h4, 32'h0000_00F0);
    brd(4'hC, a);
    load(mk_ctl(2'b10, 2'b01, 0, 0, 0, 0, 1), 32'h1234);
    bwr(4'h4, 32'h0000_FF0F);
    brd(4'hC, b);
    check("R8 input inversion", a, b);
  endtask

  task automatic t_out_view();
    logic [31:0] v;
    load(mk_ctl(2'b11, 2'b10, 0, 0, 1, 0, 1), 32'hDD7B_0F2E);
    brd(4'hC, v); check("R9 32-bit output reversal", v, 32'h74F0_DEBB);
    load(mk_ctl(2'b10, 2'b10, 0, 0, 1, 0, 1), 32'h0000_0001);
    brd(4'hC, v); check("R9 16-bit output reversal", v, 32'h0000_8000);
    bwr(4'h0, mk_ctl(2'b01, 2'b10, 1, 0, 0, 0, 1));
    brd(4'hC, v); check("R10 8-bit output inversion", v, 32'h0000_00FE);
    bwr(4'h0, mk_ctl(2'b01, 2'b10, 0, 0, 0, 0, 1));
    brd(4'hC, v); check("R10 state kept after inverted view", v, 32'h0000_0001);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    load(mk_ctl(2'b11, 2'b10, 0, 0, 0, 0, 0), 32'hCAFE_1234);
    brd(4'hC, v); check("R3 reload while disabled", v, 32'hCAFE_1234);
    bwr(4'h4, 32'h1111_2222);
    brd(4'hC, v); check("R4 data ignored while disabled", v, 32'hCAFE_1234);
    bwr(4'h0, mk_ctl(2'b11, 2'b10, 0, 0, 0, 0, 1));
    bwr(4'hC, 32'h0);
    brd(4'hC, v); check("R4 checksum write ignored", v, 32'hCAFE_1234);
    brd(4'h8, v); check("R4 seed untouched by checksum write", v, 32'hCAFE_1234);
    brd(4'h0, v); check("R3 strobe bit reads 0", v, mk_ctl(2'b11, 2'b10, 0, 0, 0, 0, 1));
  endtask

  task automatic t_mixed();
    logic [31:0] v, st, ctl, seed, d;
    logic [31:0] x = 32'h2468_ACE1;
    for (int n = 0; n < 40; n++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      ctl = {x[31:24], 22'b0, 1'b0, (n % 5 != 0)};
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      seed = x;
      load(ctl, seed);
      st = seed;
      for (int k = 0; k < 4; k++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        d = x;
        bwr(4'h4, d);
        if (ctl[0]) st = ref_word(st, d, ctl);
      end
      brd(4'hC, v);
      check("R5-R10 mixed options", v, ref_view(st, ctl));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_ctl_readback();
    t_check_values();
    t_lengths();
    t_in_rev();
    t_in_inv();
    t_out_view();
    t_ignored();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule